// File: doc/BRIEF.md
# Packed-Integer Instruction Fault Checker

This block decides, for one 128-bit packed-integer instruction at a time, whether the instruction may execute or which single fault it must raise. Each cycle that `valid_i` is high, it samples a snapshot of the machine state. That snapshot holds the extension-present flag, the emulate, task-switch and OS save/restore control bits, the alignment-mode bit and the alignment-check enable, the processor mode, whether a memory operand is used and its effective address, and status flags for segment-limit violations, a null data segment and a page miss. One cycle later it presents the result.

Internally, a cause evaluator turns the snapshot into raw fault requests. A fixed-priority picker then keeps the highest request. A three-state controller registers the outcome. The states are `ST_IDLE` (no result), `ST_GRANT` (the instruction may proceed) and `ST_FAULT` (one fault bit is set). From any state, a strobe with no cause moves to `ST_GRANT`. A strobe with at least one cause moves to `ST_FAULT`. A cycle without a strobe moves to `ST_IDLE`. So each result lasts exactly one cycle per strobe.

Fault vector bit positions, in priority order with bit 0 highest: bit 0 invalid opcode, bit 1 device not available, bit 2 stack fault, bit 3 general protection, bit 4 page fault, bit 5 alignment check. Mode codes: 0 real, 1 virtual-8086, 2 protected, 3 treated as protected.

Top module: `simd_fault_checker`

## Requirements
- R1: A strobe with the extension flag clear, the emulate bit set, or the OS save/restore bit clear yields fault bit 0 (invalid opcode) on the next cycle.
- R2: The task-switch bit set yields fault bit 1 (device not available) when no invalid-opcode cause is present.
- R3: A memory operand whose address is not a multiple of 16 raises fault bit 3 (general protection) when the alignment-mode bit is 0, in every mode.
- R4: A misaligned memory operand raises fault bit 5 (alignment check) only when the alignment-mode bit is 1, alignment checking is enabled and the mode is not real. With the alignment-mode bit 1 and no alignment fault, the misalignment causes no fault at all.
- R5: A stack-segment limit or canonical violation raises fault bit 2 (stack fault). A data-segment limit or canonical violation raises fault bit 3 (general protection). Both apply in every mode.
- R6: A null data segment raises fault bit 3 only in protected mode (code 2 or 3). In real and virtual-8086 modes it is ignored.
- R7: A page miss raises fault bit 4 (page fault) only in virtual-8086 and protected modes. In real mode it is ignored.
- R8: When several causes are active, exactly one fault bit is set, and it is the lowest-numbered active cause (order: invalid opcode, device not available, stack, general protection, page, alignment).
- R9: With the memory-operand flag clear, the alignment, segment, null-segment and page inputs have no effect.
- R10: The cycle after each strobe, `result_vld_o` is 1 and `proceed_o` is 1 exactly when no fault bit is set. A cycle after no strobe shows `result_vld_o`, `proceed_o` and all fault bits at 0.
- R11: While reset is held and after its release, with no strobe, all outputs are 0.
- R12: Mode code 3 behaves as protected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Sample strobe for the snapshot |
| feat_ok_i | input | 1 | Packed-integer extension present |
| cr0_emul_i | input | 1 | Emulate control bit |
| cr0_tswitch_i | input | 1 | Task-switch control bit |
| cr4_fxsave_i | input | 1 | OS save/restore support bit |
| align_mode_i | input | 1 | 0: misalignment is general protection, 1: misalignment may be alignment check |
| align_chk_en_i | input | 1 | Alignment checking enabled |
| cpu_mode_i | input | 2 | Processor mode code |
| mem_op_i | input | 1 | Instruction uses a memory operand |
| addr_i | input | ADDR_W | Effective address of the memory operand |
| ss_bad_i | input | 1 | Stack segment limit or canonical violation |
| ds_bad_i | input | 1 | Data segment limit or canonical violation |
| ds_null_i | input | 1 | Null data segment used |
| page_miss_i | input | 1 | Page translation fault |
| fault_o | output | 6 | One-hot fault vector |
| proceed_o | output | 1 | Instruction may execute |
| result_vld_o | output | 1 | A result is presented this cycle |

## Verification
The hardest cases to reach are those where the outcome depends on several inputs together. Examples are a misaligned access whose fault changes with the alignment-mode bit, the check enable and the mode, and a pile-up of causes where only priority decides the winner. The directed tasks build these snapshots explicitly: the same misaligned address is tried in each mode with each alignment setting, and causes are stacked in pairs to show which one wins. Back-to-back strobes that alternate between clean and faulting snapshots show that the controller moves between the grant and fault states without passing through idle.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;

    localparam int NUM_FAULTS = 6;

    // bit positions, in priority order (bit 0 wins)
    localparam int F_UD = 0;
    localparam int F_NM = 1;
    localparam int F_SS = 2;
    localparam int F_GP = 3;
    localparam int F_PF = 4;
    localparam int F_AC = 5;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_V86  = 2'd1,
        MODE_PROT = 2'd2,
        MODE_RSVD = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_FAULT = 2'd2
    } chk_state_e;

endpackage

// File: rtl/fault_cause_eval.sv
module fault_cause_eval
    import simd_fault_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int ALIGN_BYTES = 16
) (
    input  logic                  feat_ok_i,
    input  logic                  cr0_emul_i,
    input  logic                  cr0_tswitch_i,
    input  logic                  cr4_fxsave_i,
    input  logic                  align_mode_i,
    input  logic                  align_chk_en_i,
    input  logic [1:0]            cpu_mode_i,
    input  logic                  mem_op_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  ss_bad_i,
    input  logic                  ds_bad_i,
    input  logic                  ds_null_i,
    input  logic                  page_miss_i,
    output logic [NUM_FAULTS-1:0] cause_o
);

    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

    logic misaligned;
    logic is_real;
    logic is_prot;

    assign misaligned = |addr_i[ALIGN_LSB-1:0];
    assign is_real    = (cpu_mode_i == MODE_REAL);
    assign is_prot    = (cpu_mode_i == MODE_PROT) || (cpu_mode_i == MODE_RSVD);

    always_comb begin
        cause_o       = '0;
        cause_o[F_UD] = !feat_ok_i || cr0_emul_i || !cr4_fxsave_i;
        cause_o[F_NM] = cr0_tswitch_i;
        if (mem_op_i) begin
            cause_o[F_SS] = ss_bad_i;
            cause_o[F_GP] = ds_bad_i
                         || (ds_null_i && is_prot)
                         || (misaligned && !align_mode_i);
            cause_o[F_PF] = page_miss_i && !is_real;
            cause_o[F_AC] = misaligned && align_mode_i && align_chk_en_i && !is_real;
        end
    end

endmodule

// File: rtl/fault_prio_pick.sv
module fault_prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);

    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign gnt_o[i]  = req_i[i] && !seen[i];
        assign seen[i+1] = seen[i] || req_i[i];
    end

endmodule

// File: rtl/simd_fault_checker.sv
module simd_fault_checker
    import simd_fault_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int ALIGN_BYTES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic                  feat_ok_i,
    input  logic                  cr0_emul_i,
    input  logic                  cr0_tswitch_i,
    input  logic                  cr4_fxsave_i,
    input  logic                  align_mode_i,
    input  logic                  align_chk_en_i,
    input  logic [1:0]            cpu_mode_i,
    input  logic                  mem_op_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  ss_bad_i,
    input  logic                  ds_bad_i,
    input  logic                  ds_null_i,
    input  logic                  page_miss_i,
    output logic [NUM_FAULTS-1:0] fault_o,
    output logic                  proceed_o,
    output logic                  result_vld_o
);

    logic [NUM_FAULTS-1:0] cause;
    logic [NUM_FAULTS-1:0] winner;
    logic [NUM_FAULTS-1:0] fault_q;
    chk_state_e            state_q, state_d;

    fault_cause_eval #(
        .ADDR_W      (ADDR_W),
        .ALIGN_BYTES (ALIGN_BYTES)
    ) u_cause (
        .feat_ok_i      (feat_ok_i),
        .cr0_emul_i     (cr0_emul_i),
        .cr0_tswitch_i  (cr0_tswitch_i),
        .cr4_fxsave_i   (cr4_fxsave_i),
        .align_mode_i   (align_mode_i),
        .align_chk_en_i (align_chk_en_i),
        .cpu_mode_i     (cpu_mode_i),
        .mem_op_i       (mem_op_i),
        .addr_i         (addr_i),
        .ss_bad_i       (ss_bad_i),
        .ds_bad_i       (ds_bad_i),
        .ds_null_i      (ds_null_i),
        .page_miss_i    (page_miss_i),
        .cause_o        (cause)
    );

    fault_prio_pick #(
        .N (NUM_FAULTS)
    ) u_pick (
        .req_i (cause),
        .gnt_o (winner)
    );

    // next-state decision
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_FAULT: begin
                if (valid_i) state_d = (|cause) ? ST_FAULT : ST_GRANT;
                else         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and captured winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fault_q <= '0;
        end else begin
            state_q <= state_d;
            fault_q <= valid_i ? winner : '0;
        end
    end

    // outputs from state
    always_comb begin
        proceed_o    = 1'b0;
        result_vld_o = 1'b0;
        fault_o      = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: begin
                proceed_o    = 1'b1;
                result_vld_o = 1'b1;
            end
            ST_FAULT: begin
                result_vld_o = 1'b1;
                fault_o      = fault_q;
            end
            default: ;
        endcase
    end

    p_onehot_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_o));

    p_proceed_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proceed_o |-> (fault_o == '0));

    p_strobe_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (result_vld_o && (proceed_o != (|fault_o))));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!result_vld_o && !proceed_o && fault_o == '0));

    p_ud_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !feat_ok_i) |=> fault_o[F_UD]);

    p_nm_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cr0_tswitch_i && feat_ok_i && !cr0_emul_i && cr4_fxsave_i)
        |=> fault_o[F_NM]);

    p_reg_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mem_op_i) |=> (fault_o[F_AC:F_SS] == '0));

    p_real_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cpu_mode_i == MODE_REAL) |=> (!fault_o[F_PF] && !fault_o[F_AC]));

endmodule

// File: tb/simd_fault_checker_test.sv
module simd_fault_checker_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 64;

    localparam logic [5:0] X_NONE = 6'b000000;
    localparam logic [5:0] X_UD   = 6'b000001;
    localparam logic [5:0] X_NM   = 6'b000010;
    localparam logic [5:0] X_SS   = 6'b000100;
    localparam logic [5:0] X_GP   = 6'b001000;
    localparam logic [5:0] X_PF   = 6'b010000;
    localparam logic [5:0] X_AC   = 6'b100000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          valid_i;
    logic          feat_ok_i, cr0_emul_i, cr0_tswitch_i, cr4_fxsave_i;
    logic          align_mode_i, align_chk_en_i;
    logic [1:0]    cpu_mode_i;
    logic          mem_op_i;
    logic [AW-1:0] addr_i;
    logic          ss_bad_i, ds_bad_i, ds_null_i, page_miss_i;
    logic [5:0]    fault_o;
    logic          proceed_o, result_vld_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_fault_checker #(.ADDR_W(AW), .ALIGN_BYTES(16)) uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .feat_ok_i(feat_ok_i), .cr0_emul_i(cr0_emul_i),
        .cr0_tswitch_i(cr0_tswitch_i), .cr4_fxsave_i(cr4_fxsave_i),
        .align_mode_i(align_mode_i), .align_chk_en_i(align_chk_en_i),
        .cpu_mode_i(cpu_mode_i), .mem_op_i(mem_op_i), .addr_i(addr_i),
        .ss_bad_i(ss_bad_i), .ds_bad_i(ds_bad_i), .ds_null_i(ds_null_i),
        .page_miss_i(page_miss_i), .fault_o(fault_o),
        .proceed_o(proceed_o), .result_vld_o(result_vld_o)
    );

    task automatic expect_out(string req, logic [5:0] ef, logic ep, logic ev);
        checks++;
        if (fault_o !== ef || proceed_o !== ep || result_vld_o !== ev) begin
            fails++;
            $display("FAIL %s: fault=%b proceed=%b vld=%b, expected fault=%b proceed=%b vld=%b",
                     req, fault_o, proceed_o, result_vld_o, ef, ep, ev);
        end
    endtask

    // clean protected-mode snapshot, register operand, aligned address
    task automatic clean();
        feat_ok_i = 1; cr0_emul_i = 0; cr0_tswitch_i = 0; cr4_fxsave_i = 1;
        align_mode_i = 0; align_chk_en_i = 0; cpu_mode_i = 2'd2;
        mem_op_i = 0; addr_i = 64'h1000;
        ss_bad_i = 0; ds_bad_i = 0; ds_null_i = 0; page_miss_i = 0;
    endtask

    // one strobe, result checked the cycle after
    task automatic strobe(string req, logic [5:0] ef);
        @(negedge clk) valid_i = 1;
        @(negedge clk) valid_i = 0;
        expect_out(req, ef, ef == X_NONE, 1'b1);
    endtask

    task automatic t_reset();
        expect_out("R11 reset", X_NONE, 0, 0);
        @(negedge clk);
        expect_out("R11 idle after reset", X_NONE, 0, 0);
    endtask

    task automatic t_clean();
        clean(); strobe("R10 clean proceeds", X_NONE);
        @(negedge clk);
        expect_out("R10 no strobe clears", X_NONE, 0, 0);
    endtask

    task automatic t_ud();
        clean(); feat_ok_i = 0;    strobe("R1 feature absent", X_UD);
        clean(); cr0_emul_i = 1;   strobe("R1 emulate set", X_UD);
        clean(); cr4_fxsave_i = 0; strobe("R1 os support clear", X_UD);
    endtask

    task automatic t_nm();
        clean(); cr0_tswitch_i = 1; strobe("R2 task switch", X_NM);
        clean(); cr0_tswitch_i = 1; cr0_emul_i = 1;
        strobe("R8 ud beats nm", X_UD);
    endtask

    task automatic t_align();
        clean(); mem_op_i = 1; addr_i = 64'h1008;
        strobe("R3 misaligned mode0 prot", X_GP);
        cpu_mode_i = 2'd0; strobe("R3 misaligned mode0 real", X_GP);
        clean(); mem_op_i = 1; addr_i = 64'h1008; align_mode_i = 1;
        strobe("R4 mode1 check off", X_NONE);
        align_chk_en_i = 1; strobe("R4 mode1 check on prot", X_AC);
        cpu_mode_i = 2'd1;  strobe("R4 mode1 check on v86", X_AC);
        cpu_mode_i = 2'd0;  strobe("R4 mode1 check on real", X_NONE);
        clean(); mem_op_i = 1; addr_i = 64'h1010;
        strobe("R3 aligned no fault", X_NONE);
        addr_i = 64'h1001; strobe("R3 low bit misaligned", X_GP);
    endtask

    task automatic t_seg();
        clean(); mem_op_i = 1; ss_bad_i = 1; strobe("R5 stack limit", X_SS);
        clean(); mem_op_i = 1; ds_bad_i = 1; strobe("R5 data limit", X_GP);
        ss_bad_i = 1; strobe("R8 ss beats gp", X_SS);
        clean(); mem_op_i = 1; ss_bad_i = 1; cpu_mode_i = 2'd0;
        strobe("R5 stack limit real", X_SS);
        clean(); mem_op_i = 1; cr0_tswitch_i = 1; ss_bad_i = 1;
        strobe("R8 nm beats ss", X_NM);
    endtask

    task automatic t_null();
        clean(); mem_op_i = 1; ds_null_i = 1; strobe("R6 null prot", X_GP);
        cpu_mode_i = 2'd1; strobe("R6 null v86 ignored", X_NONE);
        cpu_mode_i = 2'd0; strobe("R6 null real ignored", X_NONE);
        cpu_mode_i = 2'd3; strobe("R12 null mode3", X_GP);
    endtask

    task automatic t_pf();
        clean(); mem_op_i = 1; page_miss_i = 1; strobe("R7 page prot", X_PF);
        cpu_mode_i = 2'd1; strobe("R7 page v86", X_PF);
        cpu_mode_i = 2'd0; strobe("R7 page real ignored", X_NONE);
        clean(); mem_op_i = 1; page_miss_i = 1; addr_i = 64'h1004;
        align_mode_i = 1; align_chk_en_i = 1;
        strobe("R8 pf beats ac", X_PF);
        align_mode_i = 0; strobe("R8 gp beats pf", X_GP);
    endtask

    task automatic t_regonly();
        clean(); addr_i = 64'h1003; align_mode_i = 1; align_chk_en_i = 1;
        ss_bad_i = 1; ds_bad_i = 1; ds_null_i = 1; page_miss_i = 1;
        strobe("R9 register operand ignores memory causes", X_NONE);
        align_mode_i = 0; strobe("R9 register operand mode0", X_NONE);
    endtask

    task automatic t_b2b();
        clean();
        @(negedge clk) valid_i = 1;
        @(negedge clk);
        expect_out("R10 back-to-back first", X_NONE, 1, 1);
        mem_op_i = 1; ds_bad_i = 1;
        @(negedge clk);
        expect_out("R10 back-to-back second", X_GP, 0, 1);
        clean();
        @(negedge clk) valid_i = 0;
        expect_out("R10 back-to-back third", X_NONE, 1, 1);
        @(negedge clk);
        expect_out("R10 back-to-back end", X_NONE, 0, 0);
    endtask

    initial begin
        rst_n = 0; valid_i = 0; clean();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_reset();
        t_clean();
        t_ud();
        t_nm();
        t_align();
        t_seg();
        t_null();
        t_pf();
        t_regonly();
        t_b2b();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule